// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Counting and Idle Timeout

This block turns an asynchronous serial line into characters. It takes one sample of the line on every pulse of a 16x oversampling tick. A character is one start bit, 5 to 14 data bits sent least significant bit first, an optional parity bit (even or odd), and one or two stop bits. Each completed character is presented for one clock on a valid strobe. The strobe carries the right-justified data, a framing-error flag and a parity-error flag.

When the receiver is switched on, it first waits until the line has been seen high. Only after that does it look for a start bit, so a line that is stuck low at switch-on produces nothing. A character that is zero in every data bit, in the parity bit and in the first stop bit is a break character. Break characters are not delivered as data. While the line stays low, one further break character is counted for each full character time. When the line returns high, the total is reported with a one-clock break-end strobe.

While the receiver waits for a start bit with the line high, it pulses an idle strobe once per character time. An idle-timeout counter is reloaded on every completed character and counts down one step per idle strobe. When it reaches zero, it raises a buffer-close pulse, so the logic that stores characters can close its buffer. Placing characters in memory belongs to that outer logic.

Top module: `uart_brk_rx`

## Requirements
- R1: With `enable` low, the receiver is held in its hunt state and emits no strobes. After `enable` rises, a line that is held low produces no character and no break until the line has been sampled high at least once.
- R2: Data is taken LSB first from the mid-bit sample (the 8th tick of the start bit, then every 16 ticks). It is output right-justified in `rx_data` with all bits above the configured length at zero, for every length from 5 to 14. `rx_valid` is high for exactly one clock per character.
- R3: With `cfg_two_stop` = 1, characters with two stop bits are received back to back without error. The character is reported at the mid-point of the second stop bit.
- R4: `cfg_parity` selects the parity mode: 2'b00 or 2'b11 for none, 2'b01 for even, 2'b10 for odd. Under even or odd parity, `rx_par_err` is 1 when the data bits and the parity bit together do not have the selected parity. The data is still delivered. With no parity, `rx_par_err` is 0.
- R5: A character whose first stop bit samples 0 and which has at least one data or parity bit at 1 is delivered with `rx_frame_err` = 1.
- R6: A character that is 0 in every data bit, in the parity bit (if present) and in the first stop bit is a break character. It never raises `rx_valid`.
- R7: After a break character, each further full character time of low line adds one break character. When a 1 is sampled, `brk_end` pulses for one clock and `brk_count` holds the total, which is at least 1.
- R8: While the receiver waits for a start bit with the line high, `idle_det` pulses once for every character time of 16 × (1 + data bits + parity bit + stop bits) ticks.
- R9: Every completed character, including a break character, loads the idle-timeout counter from `idle_to_load`. Each `idle_det` pulse decrements the counter while it is non-zero. When the counter steps from 1 to 0 with `idle_to_en` = 1, `buf_close` pulses once, in the same clock as `idle_det`.
- R10: While `tick16` is low, the line is not sampled. No character and no idle pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver on; low forces the hunt state |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_data_bits | input | 4 | Data length; values below 5 act as 5, above 14 as 14 |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| idle_to_en | input | 1 | Allows the idle timeout to close a buffer |
| idle_to_load | input | 16 | Idle character times before a close |
| rx_valid | output | 1 | One-clock strobe per received character |
| rx_data | output | 14 | Received data, right-justified |
| rx_frame_err | output | 1 | First stop bit was 0 |
| rx_par_err | output | 1 | Parity mismatch |
| brk_end | output | 1 | One-clock strobe when a break ends |
| brk_count | output | 8 | Break characters in the break that just ended |
| idle_det | output | 1 | One pulse per idle character time |
| buf_close | output | 1 | Idle timeout reached zero |

## Verification
A bit counter that is off by one shows up on the same strobe as a wrongly shifted `rx_data`, a false framing error, or data bits above the configured length. A slipped sample point shows up as an error on the parity flag. A break tracker in the wrong state either leaks a break as a `rx_valid` or gives a `brk_count` that differs from the low time divided by the character time, visible on the `brk_end` strobe. An idle or timeout counter with the wrong value is seen only hundreds of clocks later, as an `idle_det` or `buf_close` at the wrong moment. The bench therefore counts these strobes over windows whose edges are tens of cycles away from the expected pulse times.

// File: rtl/uart_brk_rx_pkg.sv
`timescale 1ns/1ps
package uart_brk_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_PAR   = 3'd4,
    ST_STOP  = 3'd5,
    ST_BRK   = 3'd6
  } rx_state_e;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/uart_brk_rx_sync.sv
`timescale 1ns/1ps
module uart_brk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[N-2:0], din};
  end

  assign dout = sr[N-1];
endmodule

// File: rtl/uart_brk_rx_frame.sv
`timescale 1ns/1ps
module uart_brk_rx_frame
  import uart_brk_rx_pkg::*;
#(
  parameter int DATA_MAX = 14,
  parameter int OVS      = 16,
  parameter int BITS_W   = 4,
  parameter int CT_W     = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                tick,
  input  logic                rxd,
  input  logic [BITS_W-1:0]   bits,
  input  logic                par_on,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic [CT_W-1:0]     char_ticks,
  output logic                char_vld,
  output logic [DATA_MAX-1:0] char_data,
  output logic                char_ferr,
  output logic                char_perr,
  output logic                brk_char,
  output logic                brk_done,
  output logic                line_idle
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);

  rx_state_e           st;
  logic [CNT_W-1:0]    os;
  logic [BITS_W-1:0]   bcnt;
  logic [DATA_MAX-1:0] sh;
  logic                par_acc;
  logic                zero;
  logic                stop_idx;
  logic                stop1_q;
  logic                perr_q;
  logic [CT_W-1:0]     bt;

  logic sample;
  logic s1;
  logic last_stop;
  assign sample    = tick && (os == FULL_M1);
  assign s1        = stop_idx ? stop1_q : rxd;
  assign last_stop = stop_idx || !two_stop;
  assign line_idle = (st == ST_IDLE) && rxd;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st        <= ST_HUNT;
      os        <= '0;
      bcnt      <= '0;
      sh        <= '0;
      par_acc   <= 1'b0;
      zero      <= 1'b1;
      stop_idx  <= 1'b0;
      stop1_q   <= 1'b1;
      perr_q    <= 1'b0;
      bt        <= '0;
      char_vld  <= 1'b0;
      char_data <= '0;
      char_ferr <= 1'b0;
      char_perr <= 1'b0;
      brk_char  <= 1'b0;
      brk_done  <= 1'b0;
    end else begin
      char_vld <= 1'b0;
      brk_char <= 1'b0;
      brk_done <= 1'b0;
      if (tick) begin
        unique case (st)
          ST_HUNT: if (rxd) st <= ST_IDLE;
          ST_IDLE: begin
            if (!rxd) begin
              st <= ST_START;
              os <= '0;
            end
          end
          ST_START: begin
            if (os == HALF_M1) begin
              os <= '0;
              if (!rxd) begin
                st       <= ST_DATA;
                bcnt     <= '0;
                sh       <= '0;
                par_acc  <= 1'b0;
                zero     <= 1'b1;
                perr_q   <= 1'b0;
                stop_idx <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              os <= os + 1'b1;
            end
          end
          ST_DATA: begin
            if (sample) begin
              os      <= '0;
              sh      <= {rxd, sh[DATA_MAX-1:1]};
              par_acc <= par_acc ^ rxd;
              zero    <= zero & ~rxd;
              if (bcnt == bits - 1'b1) st <= par_on ? ST_PAR : ST_STOP;
              else                     bcnt <= bcnt + 1'b1;
            end else begin
              os <= os + 1'b1;
            end
          end
          ST_PAR: begin
            if (sample) begin
              os     <= '0;
              zero   <= zero & ~rxd;
              perr_q <= (par_acc ^ rxd) != par_odd;
              st     <= ST_STOP;
            end else begin
              os <= os + 1'b1;
            end
          end
          ST_STOP: begin
            if (sample) begin
              os <= '0;
              if (last_stop) begin
                if (zero && !s1) begin
                  brk_char <= 1'b1;
                  bt       <= '0;
                  st       <= ST_BRK;
                end else begin
                  char_vld  <= 1'b1;
                  char_data <= sh >> (BITS_W'(DATA_MAX) - bits);
                  char_ferr <= !s1;
                  char_perr <= perr_q;
                  st        <= ST_IDLE;
                end
              end else begin
                stop_idx <= 1'b1;
                stop1_q  <= rxd;
              end
            end else begin
              os <= os + 1'b1;
            end
          end
          ST_BRK: begin
            if (rxd) begin
              brk_done <= 1'b1;
              st       <= ST_IDLE;
            end else if (bt == char_ticks - 1'b1) begin
              bt       <= '0;
              brk_char <= 1'b1;
            end else begin
              bt <= bt + 1'b1;
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx_brk.sv
`timescale 1ns/1ps
module uart_brk_rx_brk #(
  parameter int BRK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             brk_char,
  input  logic             brk_done,
  output logic             brk_end,
  output logic [BRK_W-1:0] brk_count
);
  logic [BRK_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt       <= '0;
      brk_end   <= 1'b0;
      brk_count <= '0;
    end else begin
      brk_end <= 1'b0;
      if (brk_done) begin
        brk_end   <= 1'b1;
        brk_count <= cnt;
        cnt       <= '0;
      end else if (brk_char && (cnt != '1)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx_idle.sv
`timescale 1ns/1ps
module uart_brk_rx_idle #(
  parameter int IDLE_W = 16,
  parameter int CT_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              line_idle,
  input  logic              char_seen,
  input  logic [CT_W-1:0]   char_ticks,
  input  logic              to_en,
  input  logic [IDLE_W-1:0] to_load,
  output logic              idle_pulse,
  output logic              close
);
  logic [CT_W-1:0]   it_cnt;
  logic [IDLE_W-1:0] timer;
  logic              idle_hit;

  assign idle_hit = line_idle && tick && (it_cnt == char_ticks - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      it_cnt     <= '0;
      idle_pulse <= 1'b0;
    end else begin
      idle_pulse <= idle_hit;
      if (!line_idle || idle_hit) it_cnt <= '0;
      else if (tick)              it_cnt <= it_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      timer <= '0;
      close <= 1'b0;
    end else begin
      close <= 1'b0;
      if (char_seen) begin
        timer <= to_load;
      end else if (idle_hit && (timer != '0)) begin
        timer <= timer - 1'b1;
        close <= to_en && (timer == IDLE_W'(1));
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
`timescale 1ns/1ps
module uart_brk_rx
  import uart_brk_rx_pkg::*;
#(
  parameter int DATA_MAX    = 14,
  parameter int DATA_MIN    = 5,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_W      = 16,
  parameter int BRK_W       = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               enable,
  input  logic                               tick16,
  input  logic                               rxd,
  input  logic [$clog2(DATA_MAX+1)-1:0]      cfg_data_bits,
  input  logic [1:0]                         cfg_parity,
  input  logic                               cfg_two_stop,
  input  logic                               idle_to_en,
  input  logic [IDLE_W-1:0]                  idle_to_load,
  output logic                               rx_valid,
  output logic [DATA_MAX-1:0]                rx_data,
  output logic                               rx_frame_err,
  output logic                               rx_par_err,
  output logic                               brk_end,
  output logic [BRK_W-1:0]                   brk_count,
  output logic                               idle_det,
  output logic                               buf_close
);
  localparam int BITS_W = $clog2(DATA_MAX + 1);
  localparam int CT_W   = $clog2(OVS * (DATA_MAX + 4) + 1);

  logic              rxd_s;
  logic [BITS_W-1:0] bits_eff;
  logic              par_on;
  logic              par_odd;
  logic [CT_W-1:0]   char_ticks;
  logic              brk_char;
  logic              brk_done;
  logic              line_idle;

  always_comb begin
    if (cfg_data_bits < BITS_W'(DATA_MIN))      bits_eff = BITS_W'(DATA_MIN);
    else if (cfg_data_bits > BITS_W'(DATA_MAX)) bits_eff = BITS_W'(DATA_MAX);
    else                                        bits_eff = cfg_data_bits;
  end

  assign par_on     = (cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD);
  assign par_odd    = (cfg_parity == PAR_ODD);
  assign char_ticks = CT_W'(OVS) * (CT_W'(bits_eff) + CT_W'(par_on)
                                    + (cfg_two_stop ? CT_W'(3) : CT_W'(2)));

  uart_brk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  uart_brk_rx_frame #(
    .DATA_MAX(DATA_MAX),
    .OVS     (OVS),
    .BITS_W  (BITS_W),
    .CT_W    (CT_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .en        (enable),
    .tick      (tick16),
    .rxd       (rxd_s),
    .bits      (bits_eff),
    .par_on    (par_on),
    .par_odd   (par_odd),
    .two_stop  (cfg_two_stop),
    .char_ticks(char_ticks),
    .char_vld  (rx_valid),
    .char_data (rx_data),
    .char_ferr (rx_frame_err),
    .char_perr (rx_par_err),
    .brk_char  (brk_char),
    .brk_done  (brk_done),
    .line_idle (line_idle)
  );

  uart_brk_rx_brk #(.BRK_W(BRK_W)) u_brk (
    .clk      (clk),
    .rst      (rst),
    .en       (enable),
    .brk_char (brk_char),
    .brk_done (brk_done),
    .brk_end  (brk_end),
    .brk_count(brk_count)
  );

  uart_brk_rx_idle #(.IDLE_W(IDLE_W), .CT_W(CT_W)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .en        (enable),
    .tick      (tick16),
    .line_idle (line_idle),
    .char_seen (rx_valid | brk_char),
    .char_ticks(char_ticks),
    .to_en     (idle_to_en),
    .to_load   (idle_to_load),
    .idle_pulse(idle_det),
    .close     (buf_close)
  );
endmodule

// File: rtl/uart_brk_rx_chk.sv
`timescale 1ns/1ps
module uart_brk_rx_chk
  import uart_brk_rx_pkg::*;
#(
  parameter int DATA_MAX = 14,
  parameter int BRK_W    = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          enable,
  input logic                          tick16,
  input logic [$clog2(DATA_MAX+1)-1:0] cfg_data_bits,
  input logic [1:0]                    cfg_parity,
  input logic                          idle_to_en,
  input logic                          rx_valid,
  input logic [DATA_MAX-1:0]           rx_data,
  input logic                          rx_par_err,
  input logic                          brk_end,
  input logic [BRK_W-1:0]              brk_count,
  input logic                          idle_det,
  input logic                          buf_close
);
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!rx_valid && !brk_end && !idle_det && !buf_close));

  assert_data_fits_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_data_bits >= 5 && cfg_data_bits <= DATA_MAX)
      |-> ((rx_data >> cfg_data_bits) == '0));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_no_parity_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (cfg_parity == PAR_NONE || cfg_parity == 2'b11)) |-> !rx_par_err);

  assert_break_not_data_R6: assert property (@(posedge clk) disable iff (rst)
    brk_end |-> !rx_valid);

  assert_break_count_R7: assert property (@(posedge clk) disable iff (rst)
    brk_end |-> (brk_count != '0));

  assert_close_on_idle_R9: assert property (@(posedge clk) disable iff (rst)
    buf_close |-> (idle_det && $past(idle_to_en)));

  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !tick16 |=> (!rx_valid && !idle_det));
endmodule

bind uart_brk_rx uart_brk_rx_chk #(.DATA_MAX(DATA_MAX), .BRK_W(BRK_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .tick16       (tick16),
  .cfg_data_bits(cfg_data_bits),
  .cfg_parity   (cfg_parity),
  .idle_to_en   (idle_to_en),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data),
  .rx_par_err   (rx_par_err),
  .brk_end      (brk_end),
  .brk_count    (brk_count),
  .idle_det     (idle_det),
  .buf_close    (buf_close)
);

// File: tb/tb_uart_brk_rx.sv
`timescale 1ns/1ps
module tb_uart_brk_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        tick16 = 1'b1;
  logic        rxd = 1'b1;
  logic [3:0]  cfg_data_bits = 4'd8;
  logic [1:0]  cfg_parity = 2'b00;
  logic        cfg_two_stop = 1'b0;
  logic        idle_to_en = 1'b0;
  logic [15:0] idle_to_load = 16'd0;
  logic        rx_valid;
  logic [13:0] rx_data;
  logic        rx_frame_err;
  logic        rx_par_err;
  logic        brk_end;
  logic [7:0]  brk_count;
  logic        idle_det;
  logic        buf_close;

  int nchecks = 0;
  int nfail = 0;
  int nvalid = 0;
  int nbrk = 0;
  int nidle = 0;
  int nclose = 0;
  int last_data = 0;
  int last_ferr = 0;
  int last_perr = 0;
  int last_bc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_brk_rx dut (
    .clk(clk), .rst(rst), .enable(enable), .tick16(tick16), .rxd(rxd),
    .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .idle_to_en(idle_to_en),
    .idle_to_load(idle_to_load), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .brk_end(brk_end),
    .brk_count(brk_count), .idle_det(idle_det), .buf_close(buf_close)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        nvalid++;
        last_data = int'(rx_data);
        last_ferr = int'(rx_frame_err);
        last_perr = int'(rx_par_err);
      end
      if (brk_end) begin
        nbrk++;
        last_bc = int'(brk_count);
      end
      if (idle_det) nidle++;
      if (buf_close) nclose++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input bit b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input int data, input int nbits, input int pmode,
                            input bit two, input bit stop1);
    int ones;
    ones = 0;
    drive_bit(1'b0);
    for (int i = 0; i < nbits; i++) begin
      drive_bit(((data >> i) & 1) != 0);
      ones += (data >> i) & 1;
    end
    if (pmode == 1) drive_bit((ones % 2) == 1);
    if (pmode == 2) drive_bit((ones % 2) == 0);
    drive_bit(stop1);
    if (two) drive_bit(1'b1);
  endtask

  task automatic expect_char(input string req, input int v0, input int data,
                             input int ferr, input int perr);
    chk({req, " count"}, nvalid - v0, 1);
    chk({req, " data"}, last_data, data);
    chk({req, " ferr"}, last_ferr, ferr);
    chk({req, " perr"}, last_perr, perr);
  endtask

  task automatic t_reset;
    chk("R1 reset rx_valid", int'(rx_valid), 0);
    chk("R1 reset brk_end", int'(brk_end), 0);
    chk("R1 reset idle_det", int'(idle_det), 0);
    chk("R1 reset buf_close", int'(buf_close), 0);
  endtask

  task automatic t_hunt;
    int v0, b0;
    v0 = nvalid; b0 = nbrk;
    rxd = 1'b0;
    wait_clk(50);
    enable = 1'b1;
    wait_clk(500);
    chk("R1 stuck-low line gives no char", nvalid - v0, 0);
    chk("R1 stuck-low line gives no break", nbrk - b0, 0);
    rxd = 1'b1;
    wait_clk(40);
    v0 = nvalid;
    send_frame(32'hA5, 8, 0, 0, 1);
    expect_char("R1 first char after hunt", v0, 32'hA5, 0, 0);
  endtask

  task automatic t_lengths;
    int v0;
    v0 = nvalid; send_frame(32'h5A, 8, 0, 0, 1);
    expect_char("R2 8-bit 0x5A", v0, 32'h5A, 0, 0);
    v0 = nvalid; send_frame(32'hFF, 8, 0, 0, 1);
    expect_char("R2 8-bit 0xFF", v0, 32'hFF, 0, 0);
    v0 = nvalid; send_frame(32'h00, 8, 0, 0, 1);
    expect_char("R2 8-bit 0x00 stop high", v0, 32'h00, 0, 0);
    wait_clk(20);
    cfg_data_bits = 4'd5;
    wait_clk(20);
    v0 = nvalid; send_frame(32'h15, 5, 0, 0, 1);
    expect_char("R2 5-bit", v0, 32'h15, 0, 0);
    cfg_data_bits = 4'd14;
    wait_clk(20);
    v0 = nvalid; send_frame(32'h2A5C, 14, 0, 0, 1);
    expect_char("R2 14-bit", v0, 32'h2A5C, 0, 0);
    cfg_data_bits = 4'd8;
    wait_clk(20);
  endtask

  task automatic t_parity;
    int v0;
    cfg_parity = 2'b01;
    wait_clk(20);
    v0 = nvalid; send_frame(32'h37, 8, 1, 0, 1);
    expect_char("R4 even good", v0, 32'h37, 0, 0);
    v0 = nvalid; send_frame(32'h37, 8, 2, 0, 1);
    expect_char("R4 even bad", v0, 32'h37, 0, 1);
    cfg_parity = 2'b10;
    wait_clk(20);
    v0 = nvalid; send_frame(32'h37, 8, 2, 0, 1);
    expect_char("R4 odd good", v0, 32'h37, 0, 0);
    v0 = nvalid; send_frame(32'hC8, 8, 1, 0, 1);
    expect_char("R4 odd bad", v0, 32'hC8, 0, 1);
    cfg_parity = 2'b00;
    wait_clk(20);
  endtask

  task automatic t_two_stop;
    int v0;
    cfg_two_stop = 1'b1;
    wait_clk(20);
    v0 = nvalid; send_frame(32'h81, 8, 0, 1, 1);
    expect_char("R3 two-stop first", v0, 32'h81, 0, 0);
    v0 = nvalid; send_frame(32'h7E, 8, 0, 1, 1);
    expect_char("R3 two-stop back-to-back", v0, 32'h7E, 0, 0);
    cfg_two_stop = 1'b0;
    wait_clk(20);
  endtask

  task automatic t_frame_err;
    int v0, b0;
    v0 = nvalid; b0 = nbrk;
    send_frame(32'h3C, 8, 0, 0, 0);
    rxd = 1'b1;
    wait_clk(40);
    expect_char("R5 low stop bit", v0, 32'h3C, 1, 0);
    chk("R5 not a break", nbrk - b0, 0);
  endtask

  task automatic t_break(input int low_cycles, input int exp_count);
    int v0, b0;
    v0 = nvalid; b0 = nbrk;
    rxd = 1'b0;
    wait_clk(low_cycles);
    rxd = 1'b1;
    wait_clk(40);
    chk("R6 break not delivered as data", nvalid - v0, 0);
    chk("R7 one break-end strobe", nbrk - b0, 1);
    chk("R7 break character count", last_bc, exp_count);
    wait_clk(40);
  endtask

  task automatic t_idle;
    int v0, i0;
    v0 = nvalid;
    send_frame(32'h42, 8, 0, 0, 1);
    i0 = nidle;
    wait_clk(580);
    chk("R8 char received", nvalid - v0, 1);
    chk("R8 idle pulses in 580 cycles", nidle - i0, 3);
  endtask

  task automatic t_timeout;
    int c0;
    idle_to_load = 16'd3;
    idle_to_en = 1'b1;
    wait_clk(20);
    send_frame(32'h99, 8, 0, 0, 1);
    c0 = nclose;
    wait_clk(400);
    chk("R9 no close before third idle time", nclose - c0, 0);
    wait_clk(300);
    chk("R9 close after third idle time", nclose - c0, 1);
    wait_clk(400);
    chk("R9 close fires once", nclose - c0, 1);
    idle_to_en = 1'b0;
    send_frame(32'h66, 8, 0, 0, 1);
    c0 = nclose;
    wait_clk(700);
    chk("R9 no close when disabled", nclose - c0, 0);
    idle_to_load = 16'd0;
    wait_clk(20);
  endtask

  task automatic t_tick_gate;
    int v0, i0;
    tick16 = 1'b0;
    v0 = nvalid; i0 = nidle;
    send_frame(32'h11, 8, 0, 0, 1);
    wait_clk(200);
    chk("R10 no char without tick", nvalid - v0, 0);
    chk("R10 no idle without tick", nidle - i0, 0);
    tick16 = 1'b1;
    wait_clk(40);
    v0 = nvalid;
    send_frame(32'h22, 8, 0, 0, 1);
    expect_char("R10 char after tick resumes", v0, 32'h22, 0, 0);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset;
    t_hunt;
    t_lengths;
    t_parity;
    t_two_stop;
    t_frame_err;
    t_break(400, 2);
    t_break(200, 1);
    t_idle;
    t_timeout;
    t_tick_gate;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchecks++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule